// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command pins of a two-bank, 16-bit SDRAM from reset until the memory is ready for ordinary traffic. After reset it first holds the bus idle for a long power-up pause. During that pause, clock enable and both byte masks stay high and only NOP is issued. It then runs a fixed bring-up order: one precharge that closes every bank, one mode register load, and a train of auto-refresh commands. Each of these steps is followed by idle cycles that cover its own recovery time.

All timings are counted in clock cycles and come from parameters. These are the clock rate in MHz, the pause in microseconds, the precharge, mode-load and refresh recovery times, and the number of refreshes. The mode word is also a parameter. When the last refresh has recovered, the block raises a ready flag and keeps it high. From then on the pins carry, unchanged, the command bus of the downstream memory controller. Any assertion of reset, including one partway through the sequence, restarts the order from the start of the pause.

Top module: `sdram_init_seq`

## Requirements
- R1: While rst_ni is low, init_done_o is 0, cke_o is 1, dqm_o is all ones, and the bus carries NOP, encoded {cs_n,ras_n,cas_n,we_n} = 0111.
- R2: After reset release, the bus shows NOP for exactly PAUSE_US*CLK_MHZ rising edges, and the next command is the precharge.
- R3: cke_o and every dqm_o bit stay 1 for as long as init_done_o is 0.
- R4: The precharge command is encoded 0010 and drives addr_o bit AP_BIT (10) high, so that all banks are selected.
- R5: The mode register load follows the precharge by exactly T_RP cycles.
- R6: The mode register load is encoded 0000, with addr_o equal to MODE_VAL and ba_o equal to 0.
- R7: The first auto-refresh follows the mode register load by exactly T_RSC cycles.
- R8: Exactly N_REF (8) auto-refreshes are issued, each encoded 0001, and consecutive refreshes are exactly T_RFC cycles apart.
- R9: init_done_o rises exactly T_RFC cycles after the last refresh and stays 1 until reset.
- R10: Every cycle between two sequence commands carries NOP, and no command other than precharge, mode load or refresh appears before init_done_o.
- R11: Once init_done_o is 1, every output pin equals the matching ctrl_*_i input.
- R12: Asserting rst_ni at any point, including during the refresh train or after completion, restarts the whole sequence from the pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_cke_i | input | 1 | Downstream controller clock enable |
| ctrl_cs_n_i | input | 1 | Downstream controller chip select, active low |
| ctrl_ras_n_i | input | 1 | Downstream controller row strobe, active low |
| ctrl_cas_n_i | input | 1 | Downstream controller column strobe, active low |
| ctrl_we_n_i | input | 1 | Downstream controller write enable, active low |
| ctrl_ba_i | input | BA_W | Downstream controller bank address |
| ctrl_addr_i | input | ADDR_W | Downstream controller address |
| ctrl_dqm_i | input | DQM_W | Downstream controller byte masks |
| cke_o | output | 1 | SDRAM clock enable |
| cs_n_o | output | 1 | SDRAM chip select, active low |
| ras_n_o | output | 1 | SDRAM row strobe, active low |
| cas_n_o | output | 1 | SDRAM column strobe, active low |
| we_n_o | output | 1 | SDRAM write enable, active low |
| ba_o | output | BA_W | SDRAM bank address |
| addr_o | output | ADDR_W | SDRAM address |
| dqm_o | output | DQM_W | SDRAM byte masks |
| init_done_o | output | 1 | Sequence complete, bus handed to the controller |

## Verification
The checker looks at every cycle for the following. Clock enable and the masks stay high throughout bring-up. The precharge always carries the all-bank bit, and the mode load always carries the programmed word on bank zero. Each sequence command is followed by an idle cycle. The ready flag never falls without a reset. The exact spacing is left to the bench scenarios: the length of the pause, the recovery gaps, the count of eight refreshes, and the cycle in which ready rises. The bench also covers restarts from reset in the middle of the sequence and after completion, and it checks that the controller's patterns pass through after handover.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // {ras_n, cas_n, we_n} with cs_n low
  typedef enum logic [2:0] {
    CMD_MRS = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_NOP = 3'b111
  } cmd_e;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_PRE,
    ST_WAIT_RP,
    ST_MRS,
    ST_WAIT_RSC,
    ST_REF,
    ST_WAIT_RFC,
    ST_DONE
  } state_e;

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned RST_VAL = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= CNT_W'(RST_VAL);
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned T_RP  = 2,
  parameter int unsigned T_RSC = 2,
  parameter int unsigned T_RFC = 7,
  parameter int unsigned N_REF = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             zero_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output state_e           state_o
);

  localparam int unsigned RC_W = $clog2(N_REF + 1);

  state_e          state_q, state_d;
  logic [RC_W-1:0] ref_q, ref_d;

  always_comb begin
    state_d    = state_q;
    ref_d      = ref_q;
    load_o     = 1'b0;
    load_val_o = '0;
    unique case (state_q)
      ST_PAUSE:    if (zero_i) state_d = ST_PRE;
      ST_PRE: begin
        load_o     = 1'b1;
        load_val_o = CNT_W'(T_RP - 2);
        state_d    = ST_WAIT_RP;
      end
      ST_WAIT_RP:  if (zero_i) state_d = ST_MRS;
      ST_MRS: begin
        load_o     = 1'b1;
        load_val_o = CNT_W'(T_RSC - 2);
        state_d    = ST_WAIT_RSC;
      end
      ST_WAIT_RSC: if (zero_i) state_d = ST_REF;
      ST_REF: begin
        load_o     = 1'b1;
        load_val_o = CNT_W'(T_RFC - 2);
        ref_d      = ref_q + 1'b1;
        state_d    = ST_WAIT_RFC;
      end
      ST_WAIT_RFC: begin
        if (zero_i) state_d = (ref_q == RC_W'(N_REF)) ? ST_DONE : ST_REF;
      end
      ST_DONE:     state_d = ST_DONE;
      default:     state_d = ST_PAUSE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PAUSE;
      ref_q   <= '0;
    end else begin
      state_q <= state_d;
      ref_q   <= ref_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/sdram_init_cmd.sv
module sdram_init_cmd
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned BA_W   = 1,
  parameter int unsigned DQM_W  = 2,
  parameter int unsigned AP_BIT = 10,
  parameter logic [ADDR_W-1:0] MODE_VAL = '0
) (
  input  state_e            state_i,
  input  logic              ctrl_cke_i,
  input  logic              ctrl_cs_n_i,
  input  logic              ctrl_ras_n_i,
  input  logic              ctrl_cas_n_i,
  input  logic              ctrl_we_n_i,
  input  logic [BA_W-1:0]   ctrl_ba_i,
  input  logic [ADDR_W-1:0] ctrl_addr_i,
  input  logic [DQM_W-1:0]  ctrl_dqm_i,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DQM_W-1:0]  dqm_o
);

  cmd_e cmd;

  always_comb begin
    unique case (state_i)
      ST_PRE:  cmd = CMD_PRE;
      ST_MRS:  cmd = CMD_MRS;
      ST_REF:  cmd = CMD_REF;
      default: cmd = CMD_NOP;
    endcase
  end

  always_comb begin
    if (state_i == ST_DONE) begin
      cke_o   = ctrl_cke_i;
      cs_n_o  = ctrl_cs_n_i;
      ras_n_o = ctrl_ras_n_i;
      cas_n_o = ctrl_cas_n_i;
      we_n_o  = ctrl_we_n_i;
      ba_o    = ctrl_ba_i;
      addr_o  = ctrl_addr_i;
      dqm_o   = ctrl_dqm_i;
    end else begin
      cke_o   = 1'b1;
      cs_n_o  = 1'b0;
      {ras_n_o, cas_n_o, we_n_o} = cmd;
      ba_o    = '0;
      addr_o  = '0;
      dqm_o   = '1;
      if (cmd == CMD_MRS) addr_o = MODE_VAL;
      if (cmd == CMD_PRE) addr_o[AP_BIT] = 1'b1;
    end
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned CLK_MHZ  = 100,
  parameter int unsigned PAUSE_US = 200,
  parameter int unsigned T_RP     = 2,
  parameter int unsigned T_RSC    = 2,
  parameter int unsigned T_RFC    = 7,
  parameter int unsigned N_REF    = 8,
  parameter int unsigned ADDR_W   = 11,
  parameter int unsigned BA_W     = 1,
  parameter int unsigned DQM_W    = 2,
  parameter int unsigned AP_BIT   = 10,
  parameter logic [ADDR_W-1:0] MODE_VAL = 11'h030
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_cke_i,
  input  logic              ctrl_cs_n_i,
  input  logic              ctrl_ras_n_i,
  input  logic              ctrl_cas_n_i,
  input  logic              ctrl_we_n_i,
  input  logic [BA_W-1:0]   ctrl_ba_i,
  input  logic [ADDR_W-1:0] ctrl_addr_i,
  input  logic [DQM_W-1:0]  ctrl_dqm_i,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DQM_W-1:0]  dqm_o,
  output logic              init_done_o
);

  localparam int unsigned PAUSE_CYC = PAUSE_US * CLK_MHZ;
  localparam int unsigned MAX_GAP   = (T_RP > T_RSC) ? ((T_RP > T_RFC) ? T_RP : T_RFC)
                                                     : ((T_RSC > T_RFC) ? T_RSC : T_RFC);
  localparam int unsigned MAX_LD    = (PAUSE_CYC > MAX_GAP) ? PAUSE_CYC : MAX_GAP;
  localparam int unsigned CNT_W     = $clog2(MAX_LD + 1);

  logic             tmr_zero;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  state_e           state;

  sdram_init_timer #(
    .CNT_W   (CNT_W),
    .RST_VAL (PAUSE_CYC - 1)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  sdram_init_fsm #(
    .CNT_W (CNT_W),
    .T_RP  (T_RP),
    .T_RSC (T_RSC),
    .T_RFC (T_RFC),
    .N_REF (N_REF)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .zero_i     (tmr_zero),
    .load_o     (tmr_load),
    .load_val_o (tmr_val),
    .state_o    (state)
  );

  sdram_init_cmd #(
    .ADDR_W   (ADDR_W),
    .BA_W     (BA_W),
    .DQM_W    (DQM_W),
    .AP_BIT   (AP_BIT),
    .MODE_VAL (MODE_VAL)
  ) u_cmd (
    .state_i      (state),
    .ctrl_cke_i   (ctrl_cke_i),
    .ctrl_cs_n_i  (ctrl_cs_n_i),
    .ctrl_ras_n_i (ctrl_ras_n_i),
    .ctrl_cas_n_i (ctrl_cas_n_i),
    .ctrl_we_n_i  (ctrl_we_n_i),
    .ctrl_ba_i    (ctrl_ba_i),
    .ctrl_addr_i  (ctrl_addr_i),
    .ctrl_dqm_i   (ctrl_dqm_i),
    .cke_o        (cke_o),
    .cs_n_o       (cs_n_o),
    .ras_n_o      (ras_n_o),
    .cas_n_o      (cas_n_o),
    .we_n_o       (we_n_o),
    .ba_o         (ba_o),
    .addr_o       (addr_o),
    .dqm_o        (dqm_o)
  );

  assign init_done_o = (state == ST_DONE);

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
  parameter int unsigned T_RP     = 2,
  parameter int unsigned T_RSC    = 2,
  parameter int unsigned T_RFC    = 7,
  parameter int unsigned ADDR_W   = 11,
  parameter int unsigned BA_W     = 1,
  parameter int unsigned DQM_W    = 2,
  parameter int unsigned AP_BIT   = 10,
  parameter logic [ADDR_W-1:0] MODE_VAL = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cke_o,
  input logic              cs_n_o,
  input logic              ras_n_o,
  input logic              cas_n_o,
  input logic              we_n_o,
  input logic [BA_W-1:0]   ba_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [DQM_W-1:0]  dqm_o,
  input logic              init_done_o
);

  logic [3:0] bus;
  assign bus = {cs_n_o, ras_n_o, cas_n_o, we_n_o};

  initial begin
    assert_gap_params_R10: assert (T_RP >= 2 && T_RSC >= 2 && T_RFC >= 2);
  end

  assert_cke_dqm_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done_o |-> (cke_o && (&dqm_o)));

  assert_pre_all_banks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_done_o && bus == 4'b0010) |-> addr_o[AP_BIT]);

  assert_mrs_word_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_done_o && bus == 4'b0000) |-> (addr_o == MODE_VAL && ba_o == '0));

  assert_nop_after_cmd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_done_o && bus != 4'b0111) |=> (!init_done_o && bus == 4'b0111));

  assert_known_cmds_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done_o |-> (bus inside {4'b0111, 4'b0010, 4'b0000, 4'b0001}));

  assert_done_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);

endmodule

bind sdram_init_seq sdram_init_chk #(
  .T_RP     (T_RP),
  .T_RSC    (T_RSC),
  .T_RFC    (T_RFC),
  .ADDR_W   (ADDR_W),
  .BA_W     (BA_W),
  .DQM_W    (DQM_W),
  .AP_BIT   (AP_BIT),
  .MODE_VAL (MODE_VAL)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cke_o       (cke_o),
  .cs_n_o      (cs_n_o),
  .ras_n_o     (ras_n_o),
  .cas_n_o     (cas_n_o),
  .we_n_o      (we_n_o),
  .ba_o        (ba_o),
  .addr_o      (addr_o),
  .dqm_o       (dqm_o),
  .init_done_o (init_done_o)
);

// File: tb/sdram_init_seq_bench.sv
module sdram_init_seq_bench;

  localparam int CLK_MHZ  = 10;
  localparam int PAUSE_US = 20;
  localparam int P_CYC    = CLK_MHZ * PAUSE_US;
  localparam int T_RP     = 3;
  localparam int T_RSC    = 2;
  localparam int T_RFC    = 6;
  localparam int N_REF    = 8;
  localparam logic [10:0] MODE = 11'h237;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctrl_cke_i = 1'b0, ctrl_cs_n_i = 1'b1, ctrl_ras_n_i = 1'b1;
  logic        ctrl_cas_n_i = 1'b1, ctrl_we_n_i = 1'b1;
  logic [0:0]  ctrl_ba_i = '0;
  logic [10:0] ctrl_addr_i = '0;
  logic [1:0]  ctrl_dqm_i = '0;
  logic        cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, init_done_o;
  logic [0:0]  ba_o;
  logic [10:0] addr_o;
  logic [1:0]  dqm_o;

  always #4 clk_i = ~clk_i;

  sdram_init_seq #(
    .CLK_MHZ (CLK_MHZ), .PAUSE_US (PAUSE_US), .T_RP (T_RP), .T_RSC (T_RSC),
    .T_RFC (T_RFC), .N_REF (N_REF), .MODE_VAL (MODE)
  ) u_sdram_init_seq (
    .clk_i, .rst_ni, .ctrl_cke_i, .ctrl_cs_n_i, .ctrl_ras_n_i, .ctrl_cas_n_i,
    .ctrl_we_n_i, .ctrl_ba_i, .ctrl_addr_i, .ctrl_dqm_i, .cke_o, .cs_n_o,
    .ras_n_o, .cas_n_o, .we_n_o, .ba_o, .addr_o, .dqm_o, .init_done_o
  );

  typedef struct {
    logic [3:0]  cmd;   // 4'hF marks the rise of init_done_o
    int          gap;
    logic [10:0] amask;
    logic [10:0] aval;
    string       req;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push_sequence();
    q.delete();
    q.push_back('{4'b0010, P_CYC, 11'h400, 11'h400, "R2/R4"});
    q.push_back('{4'b0000, T_RP, 11'h7ff, MODE, "R5/R6"});
    q.push_back('{4'b0001, T_RSC, 11'h000, 11'h000, "R7/R8"});
    for (int i = 1; i < N_REF; i++)
      q.push_back('{4'b0001, T_RFC, 11'h000, 11'h000, "R8"});
    q.push_back('{4'hF, T_RFC, 11'h000, 11'h000, "R9"});
  endtask

  // monitor
  int cyc, last;
  bit done_seen;
  logic [3:0] mon_cmd;
  exp_t e;
  assign mon_cmd = {cs_n_o, ras_n_o, cas_n_o, we_n_o};

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      cyc = 0; last = 0; done_seen = 0;
    end else begin
      if (!done_seen) begin
        if (init_done_o) begin
          if (q.size() == 0) check(0, "R9", "done with empty queue", 1, 0);
          else begin
            e = q.pop_front();
            check(e.cmd == 4'hF, e.req, "done before sequence end", int'(e.cmd), 15);
            check(cyc - last == e.gap, e.req, "done gap", cyc - last, e.gap);
          end
          done_seen = 1;
        end else begin
          check(cke_o && dqm_o == 2'b11, "R3", "cke/dqm during init", {cke_o, dqm_o}, 7);
          if (mon_cmd != 4'b0111) begin
            if (q.size() == 0) check(0, "R10", "unexpected command", int'(mon_cmd), 7);
            else begin
              e = q.pop_front();
              check(mon_cmd == e.cmd, e.req, "command code", int'(mon_cmd), int'(e.cmd));
              check(cyc - last == e.gap, e.req, "command gap", cyc - last, e.gap);
              check((addr_o & e.amask) == e.aval, e.req, "address",
                    int'(addr_o & e.amask), int'(e.aval));
              if (e.cmd == 4'b0000) check(ba_o == 1'b0, "R6", "bank", int'(ba_o), 0);
              last = cyc;
            end
          end
        end
      end
      cyc++;
    end
  end

  task automatic check_reset_state(input string req);
    @(negedge clk_i);
    check(init_done_o == 1'b0, req, "done in reset", int'(init_done_o), 0);
    check(mon_cmd == 4'b0111, req, "bus in reset", int'(mon_cmd), 7);
    check(cke_o == 1'b1 && dqm_o == 2'b11, req, "cke/dqm in reset", {cke_o, dqm_o}, 7);
  endtask

  task automatic start_run();
    @(posedge clk_i); #2;
    rst_ni = 1'b0;
    push_sequence();
    check_reset_state("R1");
    @(posedge clk_i); #2;
    rst_ni = 1'b1;
  endtask

  task automatic wait_done();
    while (!init_done_o) @(negedge clk_i);
    @(negedge clk_i);
    check(q.size() == 0, "R8", "items left", q.size(), 0);
  endtask

  task automatic handover(input logic [18:0] pat);
    @(posedge clk_i); #2;
    {ctrl_cke_i, ctrl_cs_n_i, ctrl_ras_n_i, ctrl_cas_n_i, ctrl_we_n_i,
     ctrl_ba_i, ctrl_addr_i, ctrl_dqm_i} = pat;
    @(negedge clk_i);
    check({cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, ba_o, addr_o, dqm_o} == pat,
          "R11", "passthrough",
          int'({cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, ba_o, addr_o, dqm_o}), int'(pat));
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk_i);
    start_run();
    wait_done();
    handover({1'b0, 4'b0011, 1'b1, 11'h5a5, 2'b01});
    handover({1'b1, 4'b1000, 1'b0, 11'h0ff, 2'b10});
    handover({1'b1, 4'b0101, 1'b1, 11'h7ff, 2'b00});
    repeat (20) @(negedge clk_i);
    check(init_done_o == 1'b1, "R9", "done held", int'(init_done_o), 1);

    // restart after completion
    start_run();
    // restart during the refresh train
    repeat (P_CYC + T_RP + T_RSC + 2 * T_RFC + 1) @(posedge clk_i);
    check(q.size() > 0 && q.size() < N_REF + 3, "R12", "mid-sequence progress", q.size(), 7);
    start_run();
    // restart early in the pause
    repeat (P_CYC / 2) @(posedge clk_i);
    start_run();
    wait_done();
    check(init_done_o == 1'b1, "R12", "done after restart", int'(init_done_o), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule